// File: doc/BRIEF.md
# SDRAM Bank Access Command Sequencer

This block sits between a simple request port and the command pins of a four-bank DDR SDRAM. A user presents a read or write request with a flat word address. The block splits the address into row, bank and column and keeps a record of the open row in every bank. It then drives the chip-select, row-strobe, column-strobe and write-enable lines, the bank select and the address bus. In every cycle where no command is due, the bus carries NOP. The gaps between dependent commands come from parameterised counters. Burst length and self-timed auto-precharge are taken from configuration pins and latched with each request.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold the request and the configuration pins steady until that edge. `req_ready` is high only when the sequencer is idle, its spacing timer has expired and no refresh is being asked for, so back-pressure lasts for the whole command sequence of the previous request. A refresh request is a plain level input. The block closes every open bank, issues AUTO REFRESH, pulses `ref_ack` with that command, and then holds off new work.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Address mapping. Column is `req_addr[9:0]`, bank is `req_addr[11:10]` and row is `req_addr[24:12]`. ACTIVE carries the row on A12:A0 and the bank on BA. READ and WRITE carry the column on A9:A0, the auto-precharge flag on A10 and zeros on A12:A11.
- R2: Commands use the encoding {CS,RAS,CAS,WE}, all active low: NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, AUTO REFRESH=0001. Every cycle with no other command shows NOP. A write request gives WRITE and a read request gives READ.
- R3: Suppose a request to a closed bank is accepted at the edge that ends cycle H. ACTIVE then appears in cycle H+1, and the READ or WRITE appears exactly T_RCD cycles after the ACTIVE.
- R4: A request whose row is already open in its bank (a row hit) issues READ or WRITE in cycle H+1 with no PRECHARGE or ACTIVE.
- R5: A request to a bank with a different open row issues PRECHARGE for that bank in cycle H+1, with A10 low. ACTIVE follows T_RP cycles later, and READ or WRITE follows T_RCD cycles after the ACTIVE.
- R6: Burst code `cfg_burst_len` is 0 or 1 for 2 beats, 2 for 4 beats and 3 for 8 beats. Without auto-precharge, the next command follows a READ or WRITE no sooner than BL/2+1 cycles. It follows exactly then when a request is already waiting.
- R7: With `cfg_auto_pre` high at acceptance, A10 is high on the READ or WRITE and the bank counts as closed afterwards. The next command comes no sooner than BL/2+T_RP cycles later, and exactly then when work is waiting.
- R8: While idle with `ref_req` high, the block acts as follows. If any bank is open, it issues PRECHARGE with A10 high and BA=0, then AUTO REFRESH T_RP cycles later. If no bank is open, it issues AUTO REFRESH at once. `ref_ack` is high in exactly the cycle of AUTO REFRESH, and all banks count as closed afterwards.
- R9: After AUTO REFRESH, no command comes for T_RFC cycles. A waiting request gets its first command exactly T_RFC cycles after the AUTO REFRESH. Refresh takes priority over a request that arrives in the same cycle.
- R10: `req_ready` is low in the cycle after any acceptance and stays low while `ref_req` is high. Burst length and auto-precharge are sampled at acceptance.
- R11: After reset, the bus shows NOP, `ref_ack` is low, `req_ready` is high and all banks count as closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, commands registered on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | Flat word address {row, bank, column} |
| cfg_burst_len | input | 2 | Burst length code, sampled at acceptance |
| cfg_auto_pre | input | 1 | Auto-precharge enable, sampled at acceptance |
| ref_req | input | 1 | Refresh wanted (level) |
| ref_ack | output | 1 | High in the AUTO REFRESH cycle |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank select |
| cmd_a | output | 13 | Address bus |

## Verification
Each result is tied to the handshake cycle H. The first command of a request is due in H+1. Later commands are due at fixed offsets of T_RP and T_RCD. The first command of the next request is due at the later of one cycle after its valid rose and the previous command plus its required spacing (BL/2+1, BL/2+T_RP or T_RFC).

The bench logs every non-NOP command with its cycle number at the falling edge, after the registered outputs have settled. It compares each logged entry against the predicted command, bank, address and cycle. Because requests are issued back to back, each spacing is checked as an exact cycle count rather than a lower bound.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001
  } sdram_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACT,
    ST_RW,
    ST_REF
  } seq_state_e;
endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] q_bank,
  input  logic [ROW_W-1:0]  q_row,
  output logic              q_open,
  output logic              q_hit,
  output logic              any_open,
  input  logic              set_en,
  input  logic [BANK_W-1:0] set_bank,
  input  logic [ROW_W-1:0]  set_row,
  input  logic              clr_en,
  input  logic [BANK_W-1:0] clr_bank,
  input  logic              clr_all
);
  localparam int NBANK = 1 << BANK_W;

  logic [NBANK-1:0] open_v;
  logic [ROW_W-1:0] row_v [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_v[b] <= 1'b0;
        row_v[b]  <= '0;
      end else if (clr_all || (clr_en && clr_bank == BANK_W'(b))) begin
        open_v[b] <= 1'b0;
      end else if (set_en && set_bank == BANK_W'(b)) begin
        open_v[b] <= 1'b1;
        row_v[b]  <= set_row;
      end
    end
  end

  assign q_open   = open_v[q_bank];
  assign q_hit    = open_v[q_bank] && (row_v[q_bank] == q_row);
  assign any_open = |open_v;
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_RFC  = 10,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        cfg_burst_len,
  input  logic              cfg_auto_pre,
  input  logic              ref_req,
  output logic              ref_ack,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BANK_W-1:0] cmd_ba,
  output logic [ROW_W-1:0]  cmd_a
);
  localparam int AP_BIT = 10;
  localparam int MAXG_A = (T_RFC > T_RCD) ? T_RFC : T_RCD;
  localparam int MAXG   = (MAXG_A > T_RP + 4) ? MAXG_A : T_RP + 4;
  localparam int GAP_W  = $clog2(MAXG + 1);

  seq_state_e        state, n_state;
  sdram_cmd_e        cmd_q, n_cmd;
  logic [BANK_W-1:0] n_ba;
  logic [ROW_W-1:0]  n_a;
  logic              n_ack;

  logic              p_write, p_ap;
  logic [1:0]        p_bl;
  logic [BANK_W-1:0] p_bank;
  logic [ROW_W-1:0]  p_row;
  logic [COL_W-1:0]  p_col;

  logic              sel_write, sel_ap;
  logic [1:0]        sel_bl;
  logic [BANK_W-1:0] sel_bank;
  logic [ROW_W-1:0]  sel_row;
  logic [COL_W-1:0]  sel_col;
  logic [GAP_W-1:0]  bl_half;

  logic              take, gap_ld, gap_zero;
  logic [GAP_W-1:0]  gap_val;
  logic              t_open, t_hit, t_any;
  logic              set_en, clr_en, clr_all;

  // In idle the live inputs are decoded; otherwise the latched request.
  assign sel_write = (state == ST_IDLE) ? req_write : p_write;
  assign sel_ap    = (state == ST_IDLE) ? cfg_auto_pre : p_ap;
  assign sel_bl    = (state == ST_IDLE) ? cfg_burst_len : p_bl;
  assign sel_col   = (state == ST_IDLE) ? req_addr[COL_W-1:0] : p_col;
  assign sel_bank  = (state == ST_IDLE) ? req_addr[COL_W +: BANK_W] : p_bank;
  assign sel_row   = (state == ST_IDLE) ? req_addr[COL_W+BANK_W +: ROW_W] : p_row;
  assign bl_half   = (sel_bl == 2'd3) ? GAP_W'(4) : (sel_bl == 2'd2) ? GAP_W'(2) : GAP_W'(1);

  assign req_ready = (state == ST_IDLE) && gap_zero && !ref_req;

  sdram_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .q_bank(sel_bank), .q_row(sel_row),
    .q_open(t_open), .q_hit(t_hit), .any_open(t_any),
    .set_en(set_en), .set_bank(sel_bank), .set_row(sel_row),
    .clr_en(clr_en), .clr_bank(sel_bank), .clr_all(clr_all)
  );

  sdram_gap_timer #(.W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n),
    .load(gap_ld), .load_val(gap_val), .expired(gap_zero)
  );

  always_comb begin
    n_state = state;
    n_cmd   = CMD_NOP;
    n_ba    = '0;
    n_a     = '0;
    n_ack   = 1'b0;
    take    = 1'b0;
    gap_ld  = 1'b0;
    gap_val = '0;
    set_en  = 1'b0;
    clr_en  = 1'b0;
    clr_all = 1'b0;
    if (gap_zero) begin
      unique case (state)
        ST_IDLE: begin
          if (ref_req) begin
            gap_ld = 1'b1;
            if (t_any) begin
              n_cmd       = CMD_PRE;
              n_a[AP_BIT] = 1'b1;
              clr_all     = 1'b1;
              gap_val     = GAP_W'(T_RP - 1);
              n_state     = ST_REF;
            end else begin
              n_cmd   = CMD_REF;
              n_ack   = 1'b1;
              gap_val = GAP_W'(T_RFC - 1);
            end
          end else if (req_valid) begin
            take   = 1'b1;
            gap_ld = 1'b1;
            n_ba   = sel_bank;
            if (t_hit) begin
              n_state = ST_RW;
              gap_ld  = 1'b0;
            end else if (t_open) begin
              n_cmd   = CMD_PRE;
              clr_en  = 1'b1;
              gap_val = GAP_W'(T_RP - 1);
              n_state = ST_ACT;
            end else begin
              n_cmd   = CMD_ACT;
              n_a     = sel_row;
              set_en  = 1'b1;
              gap_val = GAP_W'(T_RCD - 1);
              n_state = ST_RW;
            end
          end
        end
        ST_ACT: begin
          n_cmd   = CMD_ACT;
          n_ba    = sel_bank;
          n_a     = sel_row;
          set_en  = 1'b1;
          gap_ld  = 1'b1;
          gap_val = GAP_W'(T_RCD - 1);
          n_state = ST_RW;
        end
        ST_REF: begin
          n_cmd   = CMD_REF;
          n_ack   = 1'b1;
          gap_ld  = 1'b1;
          gap_val = GAP_W'(T_RFC - 1);
          n_state = ST_IDLE;
        end
        default: ;
      endcase
      // Column command: from ST_RW, or directly on a row hit in idle.
      if (n_state == ST_RW && (state == ST_RW || (take && t_hit))) begin
        n_cmd              = sel_write ? CMD_WR : CMD_RD;
        n_ba               = sel_bank;
        n_a                = '0;
        n_a[COL_W-1:0]     = sel_col;
        n_a[AP_BIT]        = sel_ap;
        clr_en             = sel_ap;
        gap_ld             = 1'b1;
        gap_val            = sel_ap ? bl_half + GAP_W'(T_RP - 1) : bl_half;
        n_state            = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cmd_q   <= CMD_NOP;
      cmd_ba  <= '0;
      cmd_a   <= '0;
      ref_ack <= 1'b0;
      p_write <= 1'b0;
      p_ap    <= 1'b0;
      p_bl    <= '0;
      p_bank  <= '0;
      p_row   <= '0;
      p_col   <= '0;
    end else begin
      state   <= n_state;
      cmd_q   <= n_cmd;
      cmd_ba  <= n_ba;
      cmd_a   <= n_a;
      ref_ack <= n_ack;
      if (take) begin
        p_write <= sel_write;
        p_ap    <= sel_ap;
        p_bl    <= sel_bl;
        p_bank  <= sel_bank;
        p_row   <= sel_row;
        p_col   <= sel_col;
      end
    end
  end

  assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_q;
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cfg_auto_pre,
  input logic              ref_req,
  input logic              ref_ack,
  input logic              cmd_cs_n,
  input logic              cmd_ras_n,
  input logic              cmd_cas_n,
  input logic              cmd_we_n,
  input logic [BANK_W-1:0] cmd_ba,
  input logic [ROW_W-1:0]  cmd_a
);
  localparam int NBANK = 1 << BANK_W;

  logic [3:0]       cmd;
  logic [NBANK-1:0] open_m;
  logic             ap_q;
  logic             is_rw;

  assign cmd   = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
  assign is_rw = (cmd == 4'b0101) || (cmd == 4'b0100);

  // Bank state rebuilt from the command bus alone.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_m <= '0;
      ap_q   <= 1'b0;
    end else begin
      if (req_valid && req_ready) ap_q <= cfg_auto_pre;
      if (cmd == 4'b0011) open_m[cmd_ba] <= 1'b1;
      else if (cmd == 4'b0010 && cmd_a[10]) open_m <= '0;
      else if (cmd == 4'b0010) open_m[cmd_ba] <= 1'b0;
      else if (is_rw && cmd_a[10]) open_m[cmd_ba] <= 1'b0;
    end
  end

  a_r3_rw_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> open_m[cmd_ba]);
  a_r5_act_needs_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0011) |-> !open_m[cmd_ba]);
  a_r8_refresh_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0001) |-> (open_m == '0));
  a_r8_ack_with_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack == (cmd == 4'b0001));
  a_r2_nop_between: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 4'b0111) |=> (cmd == 4'b0111));
  a_r7_ap_bit: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> (cmd_a[10] == ap_q));
  a_r10_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !req_ready);
  a_r10_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cfg_auto_pre(cfg_auto_pre), .ref_req(ref_req), .ref_ack(ref_ack),
  .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
  .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba), .cmd_a(cmd_a)
);

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb;
  localparam int TRCD = 3;
  localparam int TRP  = 2;
  localparam int TRFC = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, cfg_auto_pre = 1'b0, ref_req = 1'b0;
  logic [24:0] req_addr = '0;
  logic [1:0]  cfg_burst_len = 2'd1;
  logic        req_ready, ref_ack, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  cmd_ba;
  logic [12:0] cmd_a;

  always #5 clk = ~clk;

  sdram_cmd_seq #(.T_RCD(TRCD), .T_RP(TRP), .T_RFC(TRFC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .cfg_burst_len(cfg_burst_len),
    .cfg_auto_pre(cfg_auto_pre), .ref_req(ref_req), .ref_ack(ref_ack),
    .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .cmd_ba(cmd_ba), .cmd_a(cmd_a)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;

  // Log of non-NOP commands, captured at the falling edge.
  logic [3:0]  lg_cmd [64];
  logic [1:0]  lg_ba  [64];
  logic [12:0] lg_a   [64];
  int          lg_cyc [64];
  int          lg_wr = 0, lg_rd = 0;

  always @(negedge clk) begin
    if (rst_n && {cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
      lg_cmd[lg_wr % 64] = {cs_n, ras_n, cas_n, we_n};
      lg_ba[lg_wr % 64]  = cmd_ba;
      lg_a[lg_wr % 64]   = cmd_a;
      lg_cyc[lg_wr % 64] = cyc;
      lg_wr = lg_wr + 1;
    end
  end

  // Reference model state.
  logic        m_open [4];
  logic [12:0] m_row  [4];
  int          last_cyc = -100, last_dist = 0;

  task automatic check(input string tag, input logic ok, input string got, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, got, exp);
    end
  endtask

  task automatic expect_cmd(input string tag, input logic [3:0] c, input logic [1:0] ba,
                            input logic [12:0] a, input int t);
    int waited = 0;
    while (lg_rd >= lg_wr && waited < 100) begin
      @(negedge clk); #1;
      waited++;
    end
    if (lg_rd >= lg_wr) begin
      check(tag, 1'b0, "no command", $sformatf("cmd=%b ba=%0d a=%h cyc=%0d", c, ba, a, t));
    end else begin
      int i = lg_rd % 64;
      lg_rd++;
      check(tag, lg_cmd[i] == c && lg_ba[i] == ba && lg_a[i] == a && lg_cyc[i] == t,
            $sformatf("cmd=%b ba=%0d a=%h cyc=%0d", lg_cmd[i], lg_ba[i], lg_a[i], lg_cyc[i]),
            $sformatf("cmd=%b ba=%0d a=%h cyc=%0d", c, ba, a, t));
    end
  endtask

  task automatic do_req(input logic w, input logic [1:0] b, input logic [12:0] r,
                        input logic [9:0] col, input logic [1:0] bl, input logic ap);
    int v, first, t, hd;
    string sp;
    @(negedge clk); #1;
    req_write = w; req_addr = {r, b, col}; cfg_burst_len = bl; cfg_auto_pre = ap;
    req_valid = 1'b1;
    v = cyc;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    req_valid = 1'b0;
    cfg_burst_len = ~bl; cfg_auto_pre = ~ap; req_write = ~w;  // changes after acceptance must not matter (R10)
    check("R10 ready low after accept", req_ready == 1'b0, $sformatf("%b", req_ready), "0");
    first = (v + 1 > last_cyc + last_dist) ? v + 1 : last_cyc + last_dist;
    sp = (last_dist == TRFC) ? "R9 " : "R6/R7 ";
    hd = (bl == 2'd3) ? 4 : (bl == 2'd2) ? 2 : 1;
    if (m_open[b] && m_row[b] == r) begin
      t = first;
      sp = {sp, "R4 hit "};
    end else if (m_open[b]) begin
      expect_cmd({sp, "R5 precharge"}, 4'b0010, b, 13'h0, first);
      expect_cmd("R5 R1 activate after tRP", 4'b0011, b, r, first + TRP);
      t = first + TRP + TRCD;
      sp = "R5 ";
    end else begin
      expect_cmd({sp, "R3 R1 activate"}, 4'b0011, b, r, first);
      t = first + TRCD;
      sp = "R3 ";
    end
    expect_cmd({sp, "R1 R2 column command"}, w ? 4'b0100 : 4'b0101, b,
               {2'b00, ap, col}, t);
    m_open[b] = !ap;
    m_row[b]  = r;
    last_cyc  = t;
    last_dist = ap ? hd + TRP : hd + 1;
  endtask

  task automatic do_ref();
    int v, first;
    logic any;
    @(negedge clk); #1;
    ref_req = 1'b1;
    v = cyc;
    #1;
    check("R10 ready low during refresh request", req_ready == 1'b0, $sformatf("%b", req_ready), "0");
    first = (v + 1 > last_cyc + last_dist) ? v + 1 : last_cyc + last_dist;
    any = m_open[0] | m_open[1] | m_open[2] | m_open[3];
    if (any) begin
      expect_cmd("R8 precharge all", 4'b0010, 2'd0, 13'h400, first);
      first = first + TRP;
    end
    expect_cmd("R8 auto refresh", 4'b0001, 2'd0, 13'h0, first);
    check("R8 ack with refresh", ref_ack == 1'b1, $sformatf("%b", ref_ack), "1");
    ref_req = 1'b0;
    @(negedge clk); #1;
    check("R9 ready low in tRFC", req_ready == 1'b0, $sformatf("%b", req_ready), "0");
    check("R8 ack single cycle", ref_ack == 1'b0, $sformatf("%b", ref_ack), "0");
    for (int k = 0; k < 4; k++) m_open[k] = 1'b0;
    last_cyc  = first;
    last_dist = TRFC;
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int iter = 0;
    for (int k = 0; k < 4; k++) begin m_open[k] = 1'b0; m_row[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check("R11 reset NOP", {cs_n, ras_n, cas_n, we_n} == 4'b0111,
          $sformatf("%b", {cs_n, ras_n, cas_n, we_n}), "0111");
    check("R11 reset ready", req_ready == 1'b1, $sformatf("%b", req_ready), "1");
    check("R11 reset ack low", ref_ack == 1'b0, $sformatf("%b", ref_ack), "0");
    check("R11 no command logged", lg_wr == 0, $sformatf("%0d", lg_wr), "0");

    for (int b = 0; b < 4; b++)
      for (int bl = 0; bl < 4; bl++)
        for (int ap = 0; ap < 2; ap++)
          for (int w = 0; w < 2; w++) begin
            logic [12:0] r0 = 13'(b * 40 + bl * 5 + ap * 2 + w + 1);
            logic [9:0]  c0 = 10'(b * 97 + bl * 31 + w * 3 + ap * 200);
            do_req(w[0], b[1:0], r0, c0, bl[1:0], ap[0]);
            do_req(!w[0], b[1:0], r0, c0 + 10'd1, bl[1:0], ap[0]);
            do_req(w[0], b[1:0], r0 + 13'd4000, c0 + 10'd2, bl[1:0], ap[0]);
            do_req(w[0], 2'(b + 1), r0, c0 + 10'd3, bl[1:0], 1'b0);
            if (iter % 5 == 4) do_ref();
            iter++;
          end

    do_req(1'b0, 2'd2, 13'h1abc, 10'h3ff, 2'd3, 1'b0);
    do_ref();
    do_ref();
    do_req(1'b1, 2'd3, 13'h1fff, 10'h155, 2'd2, 1'b0);
    do_req(1'b0, 2'd3, 13'h1fff, 10'h2aa, 2'd2, 1'b1);

    repeat (5) @(negedge clk);
    #1;
    check("R2 only expected commands seen", lg_rd == lg_wr, $sformatf("%0d", lg_wr), $sformatf("%0d", lg_rd));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule